// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit computes a memory address from up to three terms: a base register value, an index register value multiplied by a power of two, and a signed displacement. Each term has its own enable, so a single datapath covers the common address shapes: base alone, displacement alone, base plus displacement, base plus index, and the full scaled-index sum. A separate relative mode adds the displacement to a supplied program counter to form a jump target.

The displacement comes in either a full-width form or a short 8-bit form that is sign-extended. All arithmetic wraps modulo 2^32 and there is no overflow flag. A request presented on one clock edge yields a registered address and a one-cycle valid pulse after that edge. The register file, segment translation and the memory access itself are outside this block.

Top module: `ea_gen`

## Requirements
- R1: When `req_i` is high and `pcrel_i` is low, the address registered at that edge equals (`base_en_i` ? `base_i` : 0) + (`index_en_i` ? scaled index : 0) + (`disp_en_i` ? extended displacement : 0). Base only, displacement only, base plus displacement and base plus index are special cases of this sum.
- R2: The 2-bit `scale_i` code is a left-shift amount applied to `index_i`: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8.
- R3: When `disp_short_i` is 1, the displacement is bits [7:0] of `disp_i` sign-extended from bit 7, and bits [31:8] of `disp_i` have no effect. When it is 0, all 32 bits of `disp_i` are used.
- R4: When `req_i` and `pcrel_i` are both high, the address is `pc_i` + extended displacement. In that case `base_i`, `index_i`, `scale_i` and the three enables have no effect.
- R5: `vld_o` is high in the cycle after each edge at which `req_i` was high, and low after every edge at which `req_i` was low.
- R6: After reset, `vld_o` is 0 and `ea_o` is 0.
- R7: `ea_o` changes only after an edge at which `req_i` was high. Input changes made without a request leave it unchanged.
- R8: The sum wraps modulo 2^32 and no overflow indication is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request: capture the address this cycle |
| pcrel_i | input | 1 | Relative mode: program counter plus displacement |
| base_en_i | input | 1 | Include the base term |
| index_en_i | input | 1 | Include the scaled index term |
| disp_en_i | input | 1 | Include the displacement term |
| disp_short_i | input | 1 | Use the sign-extended low 8 bits of the displacement |
| scale_i | input | 2 | Index shift amount (x1, x2, x4, x8) |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| disp_i | input | 32 | Displacement |
| pc_i | input | 32 | Program counter for relative mode |
| ea_o | output | 32 | Registered effective address |
| vld_o | output | 1 | One-cycle valid pulse for `ea_o` |

## Verification
The assertions check on every cycle that the valid pulse follows each request, that the address holds when no request is made, and that the single-term shapes are correct: base only, displacement only in both widths, index only at each scale, and relative targets with a full displacement. The bench shows the remaining behaviour. It sweeps every scale code against every combination of the enables, the relative bit and the short bit, using operand sets chosen to carry across the 32-bit boundary. Mixed sums, sign extension of negative short displacements, and the fact that relative mode ignores the base and index terms can only be shown by these scenarios.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
   // Adder implementation choices for the three-term sum
   localparam int ADD_RIPPLE = 0;
   localparam int ADD_CSA    = 1;
   // Default geometry
   localparam int DEF_AW  = 32;
   localparam int DEF_SDW = 8;
   localparam int DEF_SCW = 2;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
   parameter int AW  = 32,
   parameter int SDW = 8
) (
   input  logic          short_i,
   input  logic [AW-1:0] disp_i,
   output logic [AW-1:0] disp_o
);
   localparam int PADW = AW - SDW;

   logic [AW-1:0] short_ext;

   generate
      if (PADW > 0) begin : g_pad
         assign short_ext = {{PADW{disp_i[SDW-1]}}, disp_i[SDW-1:0]};
      end else begin : g_nopad
         assign short_ext = disp_i;
      end
   endgenerate

   assign disp_o = short_i ? short_ext : disp_i;
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
   parameter int AW  = 32,
   parameter int SCW = 2
) (
   input  logic [SCW-1:0] scale_i,
   input  logic [AW-1:0]  value_i,
   output logic [AW-1:0]  value_o
);
   localparam int NSH = 1 << SCW;

   logic [AW-1:0] shifted [NSH];

   generate
      for (genvar s = 0; s < NSH; s++) begin : g_sh
         if (s == 0) begin : g_id
            assign shifted[s] = value_i;
         end else begin : g_l
            assign shifted[s] = {value_i[AW-1-s:0], {s{1'b0}}};
         end
      end
   endgenerate

   assign value_o = shifted[scale_i];
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
   parameter int AW    = 32,
   parameter int STYLE = 0
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   input  logic [AW-1:0] c_i,
   output logic [AW-1:0] sum_o
);
   import ea_gen_pkg::*;

   generate
      if (STYLE == ADD_CSA) begin : g_csa
         logic [AW-1:0] psum;
         logic [AW-1:0] pcar;
         logic [AW-1:0] pcar_sh;
         for (genvar b = 0; b < AW; b++) begin : g_fa
            assign psum[b] = a_i[b] ^ b_i[b] ^ c_i[b];
            assign pcar[b] = (a_i[b] & b_i[b]) | (a_i[b] & c_i[b]) | (b_i[b] & c_i[b]);
         end
         assign pcar_sh = {pcar[AW-2:0], 1'b0};
         assign sum_o   = psum + pcar_sh;
      end else begin : g_ripple
         assign sum_o = a_i + b_i + c_i;
      end
   endgenerate
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int AW        = ea_gen_pkg::DEF_AW,
   parameter int SDW       = ea_gen_pkg::DEF_SDW,
   parameter int SCW       = ea_gen_pkg::DEF_SCW,
   parameter int ADD_STYLE = ea_gen_pkg::ADD_CSA
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_i,
   input  logic           pcrel_i,
   input  logic           base_en_i,
   input  logic           index_en_i,
   input  logic           disp_en_i,
   input  logic           disp_short_i,
   input  logic [SCW-1:0] scale_i,
   input  logic [AW-1:0]  base_i,
   input  logic [AW-1:0]  index_i,
   input  logic [AW-1:0]  disp_i,
   input  logic [AW-1:0]  pc_i,
   output logic [AW-1:0]  ea_o,
   output logic           vld_o
);
   localparam int MAXSH = (1 << SCW) - 1;

   generate
      if (SDW < 2 || SDW > AW) begin : g_bad_sdw
         $error("ea_gen: short displacement width out of range");
      end
      if (SCW < 1 || MAXSH >= AW) begin : g_bad_scw
         $error("ea_gen: scale code width out of range");
      end
      if (ADD_STYLE != ea_gen_pkg::ADD_RIPPLE && ADD_STYLE != ea_gen_pkg::ADD_CSA) begin : g_bad_add
         $error("ea_gen: unknown adder style");
      end
   endgenerate

   logic [AW-1:0] disp_x;
   logic [AW-1:0] idx_sc;
   logic [AW-1:0] term_a;
   logic [AW-1:0] term_b;
   logic [AW-1:0] term_c;
   logic [AW-1:0] sum_w;
   logic [AW-1:0] ea_q;
   logic          vld_q;

   ea_disp_ext #(.AW(AW), .SDW(SDW)) u_dext (
      .short_i (disp_short_i),
      .disp_i  (disp_i),
      .disp_o  (disp_x)
   );

   ea_scaler #(.AW(AW), .SCW(SCW)) u_scl (
      .scale_i (scale_i),
      .value_i (index_i),
      .value_o (idx_sc)
   );

   always_comb begin
      if (pcrel_i) begin
         term_a = pc_i;
         term_b = '0;
         term_c = disp_x;
      end else begin
         term_a = base_en_i  ? base_i : '0;
         term_b = index_en_i ? idx_sc : '0;
         term_c = disp_en_i  ? disp_x : '0;
      end
   end

   ea_adder3 #(.AW(AW), .STYLE(ADD_STYLE)) u_add (
      .a_i   (term_a),
      .b_i   (term_b),
      .c_i   (term_c),
      .sum_o (sum_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= req_i;
         if (req_i) begin
            ea_q <= sum_w;
         end
      end
   end

   assign ea_o  = ea_q;
   assign vld_o = vld_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int AW  = 32,
   parameter int SDW = 8,
   parameter int SCW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_i,
   input logic           pcrel_i,
   input logic           base_en_i,
   input logic           index_en_i,
   input logic           disp_en_i,
   input logic           disp_short_i,
   input logic [SCW-1:0] scale_i,
   input logic [AW-1:0]  base_i,
   input logic [AW-1:0]  index_i,
   input logic [AW-1:0]  disp_i,
   input logic [AW-1:0]  pc_i,
   input logic [AW-1:0]  ea_o,
   input logic           vld_o
);
   logic plain;
   assign plain = req_i && !pcrel_i;

   AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> vld_o); // R5
   AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !vld_o); // R5
   AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(ea_o)); // R7
   AST_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && base_en_i && !index_en_i && !disp_en_i) |=> ea_o == $past(base_i)); // R1
   AST_DISP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && !base_en_i && !index_en_i && disp_en_i && !disp_short_i)
      |=> ea_o == $past(disp_i)); // R1
   AST_DISP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && !base_en_i && !index_en_i && disp_en_i && disp_short_i)
      |=> ea_o == {{(AW-SDW){$past(disp_i[SDW-1])}}, $past(disp_i[SDW-1:0])}); // R3
   AST_INDEX_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
      (plain && !base_en_i && index_en_i && !disp_en_i)
      |=> ea_o == ($past(index_i) << $past(scale_i))); // R2
   AST_PCREL_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && pcrel_i && !disp_short_i)
      |=> ea_o == $past(pc_i) + $past(disp_i)); // R4
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .SDW(SDW), .SCW(SCW)) u_ea_gen_chk (.*);

// File: tb/test_ea_gen.sv
module test_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        pcrel_i = 1'b0;
   logic        base_en_i = 1'b0;
   logic        index_en_i = 1'b0;
   logic        disp_en_i = 1'b0;
   logic        disp_short_i = 1'b0;
   logic [1:0]  scale_i = 2'd0;
   logic [31:0] base_i = '0;
   logic [31:0] index_i = '0;
   logic [31:0] disp_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] ea_o;
   logic        vld_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ea_gen i_ea_gen (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .pcrel_i(pcrel_i),
      .base_en_i(base_en_i), .index_en_i(index_en_i), .disp_en_i(disp_en_i),
      .disp_short_i(disp_short_i), .scale_i(scale_i), .base_i(base_i),
      .index_i(index_i), .disp_i(disp_i), .pc_i(pc_i), .ea_o(ea_o), .vld_o(vld_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input bit pr, input bit be, input bit ie,
                                         input bit de, input bit sh, input logic [1:0] sc,
                                         input logic [31:0] b, input logic [31:0] x,
                                         input logic [31:0] d, input logic [31:0] p);
      logic [63:0] acc;
      logic [31:0] dx;
      dx = sh ? {{24{d[7]}}, d[7:0]} : d;
      if (pr) acc = 64'(p) + 64'(dx);
      else acc = (be ? 64'(b) : 64'd0) + (ie ? 64'(x) * (64'd1 << sc) : 64'd0)
                 + (de ? 64'(dx) : 64'd0);
      return acc[31:0];
   endfunction

   task automatic load_set(input int v);
      case (v)
         0: begin base_i = 32'h0000_1000; index_i = 32'h0000_0010; disp_i = 32'h0000_0080; pc_i = 32'h0040_0000; end
         1: begin base_i = 32'hFFFF_FFF0; index_i = 32'h8000_0001; disp_i = 32'hABCD_EF85; pc_i = 32'hFFFF_FFFC; end
         2: begin base_i = 32'h7FFF_FFFF; index_i = 32'h2345_6789; disp_i = 32'h1234_567F; pc_i = 32'h0000_0004; end
         default: begin base_i = 32'hDEAD_BEEF; index_i = 32'hFFFF_FFFF; disp_i = 32'hFFFF_FF00; pc_i = 32'h8000_0000; end
      endcase
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R6 vld after reset", {31'd0, vld_o}, 32'd0);
      check("R6 ea after reset", ea_o, 32'd0);
      rst_n = 1'b1;
      for (int v = 0; v < 4; v++) begin
         for (int sc = 0; sc < 4; sc++) begin
            for (int en = 0; en < 32; en++) begin
               logic [31:0] exp;
               logic [31:0] held;
               @(negedge clk);
               load_set(v);
               scale_i = 2'(sc);
               pcrel_i = en[4]; base_en_i = en[3]; index_en_i = en[2];
               disp_en_i = en[1]; disp_short_i = en[0];
               exp = model(en[4], en[3], en[2], en[1], en[0], 2'(sc), base_i, index_i, disp_i, pc_i);
               req_i = 1'b1;
               @(negedge clk);
               req_i = 1'b0;
               if (en[4]) check("R4 relative target", ea_o, exp);
               else if (en[2]) check("R2 scaled sum", ea_o, exp);
               else check("R1 term sum", ea_o, exp);
               check("R5 valid pulse", {31'd0, vld_o}, 32'd1);
               if (en[0] && en[1] && !en[4] && !en[3] && !en[2]) begin
                  // short form: upper displacement bits must not matter
                  @(negedge clk);
                  disp_i = disp_i ^ 32'hFFFF_FF00;
                  req_i = 1'b1;
                  @(negedge clk);
                  req_i = 1'b0;
                  check("R3 upper disp ignored", ea_o, exp);
               end
               if (en[4] && (en % 4 == 0)) begin
                  @(negedge clk);
                  base_i = ~base_i; index_i = index_i + 32'd7; scale_i = ~scale_i;
                  base_en_i = ~base_en_i; index_en_i = ~index_en_i; disp_en_i = ~disp_en_i;
                  req_i = 1'b1;
                  @(negedge clk);
                  req_i = 1'b0;
                  check("R4 base/index ignored", ea_o, exp);
               end
               if (sc == v && en[1:0] == 2'b10) begin
                  held = ea_o;
                  @(negedge clk);
                  check("R5 no valid when idle", {31'd0, vld_o}, 32'd0);
                  base_i = base_i + 32'h55; pc_i = ~pc_i; disp_i = ~disp_i; pcrel_i = ~pcrel_i;
                  @(negedge clk);
                  check("R7 address held", ea_o, held);
               end
            end
         end
      end
      // R8 wrap: all-ones terms
      @(negedge clk);
      pcrel_i = 0; base_en_i = 1; index_en_i = 1; disp_en_i = 1; disp_short_i = 0;
      base_i = 32'hFFFF_FFFF; index_i = 32'hFFFF_FFFF; disp_i = 32'hFFFF_FFFF; scale_i = 2'd3;
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      check("R8 modulo wrap", ea_o, 32'hFFFF_FFF6);
      // back-to-back requests give a pulse each cycle
      @(negedge clk);
      base_en_i = 1; index_en_i = 0; disp_en_i = 0; base_i = 32'h11; req_i = 1'b1;
      @(negedge clk);
      base_i = 32'h22;
      check("R5 back-to-back first", ea_o, 32'h11);
      @(negedge clk);
      req_i = 1'b0;
      check("R5 back-to-back second", ea_o, 32'h22);
      check("R5 back-to-back valid", {31'd0, vld_o}, 32'd1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule